// File: doc/BRIEF.md
# I2C Target with Command Pointer

This block connects a small register bank to an I2C or SMBus. It works from SCL and SDA samples that have already been brought into the system clock domain. It finds START, repeated START and STOP conditions. It answers to one 7-bit address. It keeps a byte-wide pointer that selects one register of the bank. A host selects a register by writing a command byte. Data bytes that follow in the same write transaction go to that register. Read transactions return the register the pointer selects.

The pointer never advances by itself. A host that wants a different register must write a new command byte. The pointer keeps its value across STOP conditions and changes only when a command byte completes, or on reset. The block drives the bus only through one open-drain enable (`sda_oe`, where 1 pulls SDA low). The pad, spike filtering, clock stretching and general-call handling all belong outside this block.

The bank side is made of plain single-cycle strobes with no back-pressure. The bank must take a write in the cycle `wr_valid` is high. It must return `rd_data` combinationally in the cycle `rd_strobe` is high, because the block captures that value in the same cycle.

Top module: `i2c_cmd_target`

## Requirements
- R1: The block answers to address {4'b0100, strap[2:0]}, strap[2] most significant. It acknowledges a match by holding SDA low through the ninth SCL pulse. A different address gets no acknowledge and produces no strobe.
- R2: The bit after the seven address bits selects the direction: 0 starts a write and 1 starts a read.
- R3: The first byte after the address in a write is acknowledged and stored as the register pointer.
- R4: Each further written byte is acknowledged. When the pointer is 1, 2 or 3, each such byte also produces a one-cycle `wr_valid` carrying the pointer on `wr_addr` and the byte on `wr_data`.
- R5: A data byte written while the pointer is 0 or above 3 is acknowledged but produces no write strobe.
- R6: The pointer does not auto-increment. Every data byte of a write, and every byte of a read, uses the same register.
- R7: In a read, `rd_strobe` pulses when the address is acknowledged and again after each controller ACK. Bytes are sent MSB first.
- R8: When the pointer is above 3, a read returns 0xFF and raises no `rd_strobe`.
- R9: A controller NACK ends the read, and the block leaves SDA released.
- R10: A START or STOP in the middle of a byte discards that byte. No strobe results, and reception restarts with an address. A STOP leaves the pointer unchanged.
- R11: `sda_oe` changes only while SCL is low. It changes one system clock after the falling edge is seen.
- R12: Synchronous reset sets the pointer to 0, makes the block idle and releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level as seen on the bus |
| strap | input | 3 | Low three bits of the target address |
| sda_oe | output | 1 | 1 pulls SDA low |
| wr_valid | output | 1 | One-cycle register write strobe |
| wr_addr | output | 2 | Register index for the write |
| wr_data | output | 8 | Byte to write |
| rd_strobe | output | 1 | One-cycle register read strobe |
| rd_addr | output | 2 | Register index for the read |
| rd_data | input | 8 | Register value, valid while rd_strobe is high |

## Verification
The bench sends several data bytes under one command byte and reads twice under one pointer. A design that auto-increments would spread these bytes across registers, and the bench would see that. It aborts a byte with a repeated START after four bits. A design that still counted the partial byte would issue a write, or lose the pointer stored earlier. It also reads from pointer 0 after a reset and from an invalid pointer. A design with the wrong reset value or without the 0xFF substitution would return the wrong byte there, and a missing read strobe shows up in the strobe counts. Finally, it watches for `sda_oe` changing while SCL is high, which on a real bus would appear as a false START or STOP.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_MACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter int          HI_W     = 4,
  parameter logic [HI_W-1:0] ADDR_HI = 4'b0100,
  parameter int          STRAP_W  = 3,
  parameter int          NUM_REGS = 4,
  localparam int         PTR_W    = $clog2(NUM_REGS),
  localparam int         ADDR_W   = HI_W + STRAP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  output logic               sda_oe,
  output logic               wr_valid,
  output logic [PTR_W-1:0]   wr_addr,
  output logic [7:0]         wr_data,
  output logic               rd_strobe,
  output logic [PTR_W-1:0]   rd_addr,
  input  logic [7:0]         rd_data
);
  localparam logic [7:0] REG_LIMIT = 8'(NUM_REGS);

  tgt_state_e        state;
  logic [3:0]        cnt;
  logic [7:0]        rx_sh, tx_sh, ptr, wdat_q;
  logic              rw_q, have_cmd, nack_q, oe_q, wv_q;
  logic [ADDR_W-1:0] own_addr;
  logic              addr_hit, ptr_readable, ptr_writable, rd_fire;
  logic [7:0]        load_val;

  assign own_addr     = {ADDR_HI, strap};
  assign addr_hit     = (rx_sh[7:1] == own_addr);
  assign ptr_readable = (ptr < REG_LIMIT);
  assign ptr_writable = (ptr != 8'd0) && (ptr < REG_LIMIT);
  assign load_val     = ptr_readable ? rd_data : 8'hFF;

  // Read pulses: on the address acknowledge of a read, and after each controller ACK
  assign rd_fire = ptr_readable && scl_fall && !start_det && !stop_det &&
                   ((state == ST_ADDR && cnt == 4'd8 && addr_hit && rx_sh[0]) ||
                    (state == ST_MACK && !nack_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      ptr      <= '0;
      wdat_q   <= '0;
      rw_q     <= 1'b0;
      have_cmd <= 1'b0;
      nack_q   <= 1'b1;
      oe_q     <= 1'b0;
      wv_q     <= 1'b0;
    end else begin
      wv_q <= 1'b0;
      if (start_det) begin
        state <= ST_ADDR;
        cnt   <= '0;
        oe_q  <= 1'b0;
      end else if (stop_det) begin
        state <= ST_IDLE;
        oe_q  <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: ;
          ST_ADDR: begin
            if (scl_rise && cnt < 4'd8) begin
              rx_sh <= {rx_sh[6:0], sda_i};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (addr_hit) begin
                oe_q  <= 1'b1;
                rw_q  <= rx_sh[0];
                state <= ST_AACK;
                if (rx_sh[0]) tx_sh <= load_val;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          ST_AACK: if (scl_fall) begin
            cnt <= '0;
            if (rw_q) begin
              state <= ST_TX;
              oe_q  <= ~tx_sh[7];
            end else begin
              state    <= ST_RX;
              oe_q     <= 1'b0;
              have_cmd <= 1'b0;
            end
          end
          ST_RX: begin
            if (scl_rise && cnt < 4'd8) begin
              rx_sh <= {rx_sh[6:0], sda_i};
              cnt   <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              oe_q  <= 1'b1;
              state <= ST_RACK;
              if (!have_cmd) begin
                ptr      <= rx_sh;
                have_cmd <= 1'b1;
              end else if (ptr_writable) begin
                wv_q   <= 1'b1;
                wdat_q <= rx_sh;
              end
            end
          end
          ST_RACK: if (scl_fall) begin
            oe_q  <= 1'b0;
            cnt   <= '0;
            state <= ST_RX;
          end
          ST_TX: if (scl_fall) begin
            if (cnt == 4'd7) begin
              oe_q  <= 1'b0;
              state <= ST_MACK;
            end else begin
              tx_sh <= {tx_sh[6:0], 1'b0};
              oe_q  <= ~tx_sh[6];
              cnt   <= cnt + 4'd1;
            end
          end
          ST_MACK: begin
            if (scl_rise) nack_q <= sda_i;
            else if (scl_fall) begin
              if (!nack_q) begin
                tx_sh <= load_val;
                oe_q  <= ~load_val[7];
                cnt   <= '0;
                state <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign sda_oe    = oe_q;
  assign wr_valid  = wv_q;
  assign wr_addr   = ptr[PTR_W-1:0];
  assign wr_data   = wdat_q;
  assign rd_strobe = rd_fire;
  assign rd_addr   = ptr[PTR_W-1:0];

  // R11
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(oe_q) |-> !scl_i);
  // R4
  wr_single_chk: assert property (@(posedge clk) disable iff (rst)
    wv_q |=> !wv_q);
  // R4
  wr_after_fall_chk: assert property (@(posedge clk) disable iff (rst)
    wv_q |-> $past(scl_fall));
  // R7
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    rd_fire |-> !wv_q);
  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (!oe_q && state == ST_IDLE));
  // R12
  reset_ptr_chk: assert property (@(posedge clk)
    rst |=> (ptr == 8'd0 && state == ST_IDLE && !oe_q));
endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target #(
  parameter int NUM_REGS = 4,
  localparam int PTR_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [2:0]       strap,
  output logic             sda_oe,
  output logic             wr_valid,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic             rd_strobe,
  output logic [PTR_W-1:0] rd_addr,
  input  logic [7:0]       rd_data
);
  logic scl_rise, scl_fall, start_det, stop_det;

  i2c_bus_events u_events (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_tgt_engine #(
    .HI_W(4), .ADDR_HI(4'b0100), .STRAP_W(3), .NUM_REGS(NUM_REGS)
  ) u_engine (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det),
    .strap(strap), .sda_oe(sda_oe),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_strobe(rd_strobe), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/tb_i2c_cmd_target.sv
`timescale 1ns/1ps
module tb_i2c_cmd_target;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] strap = 3'd5;
  logic sda_oe, wr_valid, rd_strobe;
  logic [1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic [7:0] inport = 8'h5A;
  logic [7:0] bank [4];
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0, fails = 0, wr_cnt = 0, rd_cnt = 0, oe_hi_changes = 0;
  logic oe_prev = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_cmd_target dut (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_bus), .strap(strap),
    .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_strobe(rd_strobe), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // external register bank model
  assign rd_data = (rd_addr == 2'd0) ? inport : bank[rd_addr];
  always @(posedge clk) begin
    if (wr_valid) begin bank[wr_addr] <= wr_data; wr_cnt <= wr_cnt + 1; end
    if (rd_strobe) rd_cnt <= rd_cnt + 1;
    if (!rst && sda_oe != oe_prev && scl) oe_hi_changes <= oe_hi_changes + 1;
    oe_prev <= sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic bit_io(input logic b, output logic s);
    sda_m = b; w(2);
    scl = 1'b1; w(2);
    s = sda_bus; w(2);
    scl = 1'b0; w(2);
  endtask

  task automatic i2c_start();
    if (!scl) begin sda_m = 1'b1; w(2); scl = 1'b1; w(2); end
    sda_m = 1'b0; w(4);
    scl = 1'b0; w(2);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; w(2);
    scl = 1'b1; w(4);
    sda_m = 1'b1; w(4);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(b[i], s);
    bit_io(1'b1, s);
    ack = !s;
  endtask

  task automatic rd_byte(input logic nack, output logic [7:0] v);
    logic s;
    for (int i = 7; i >= 0; i--) begin bit_io(1'b1, s); v[i] = s; end
    bit_io(nack, s);
  endtask

  // {address, command, data, expected readback, expected write strobes}
  localparam logic [39:0] VEC [5] = '{
    {8'h25, 8'h01, 8'h3C, 8'h3C, 8'd1},
    {8'h25, 8'h02, 8'hA5, 8'hA5, 8'd1},
    {8'h25, 8'h03, 8'h0F, 8'h0F, 8'd1},
    {8'h25, 8'h00, 8'h77, 8'h5A, 8'd0},
    {8'h25, 8'h07, 8'h11, 8'hFF, 8'd0}
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v, v2;
    int wc0, rc0;
    for (int i = 0; i < 4; i++) bank[i] = 8'h00;
    w(5); rst = 1'b0; w(2);
    // R12 reset state at the ports
    chk(!sda_oe && !wr_valid && !rd_strobe, "R12 reset idle", sda_oe, 0);

    for (int k = 0; k < 5; k++) begin
      logic [39:0] r;
      r = VEC[k];
      wc0 = wr_cnt;
      i2c_start();
      wr_byte({r[38:32], 1'b0}, ack); chk(ack, "R1 R2 write address ack", ack, 1);
      wr_byte(r[31:24], ack);         chk(ack, "R3 command ack", ack, 1);
      wr_byte(r[23:16], ack);         chk(ack, "R4 R5 data ack", ack, 1);
      chk(wr_cnt - wc0 == int'(r[7:0]), "R4 R5 write strobe count", wr_cnt - wc0, r[7:0]);
      i2c_start();
      wr_byte({r[38:32], 1'b1}, ack); chk(ack, "R2 read address ack", ack, 1);
      rd_byte(1'b1, v);
      i2c_stop();
      chk(v == r[15:8], "R7 R8 readback", v, r[15:8]);
    end

    // R1 foreign address
    wc0 = wr_cnt; rc0 = rd_cnt;
    i2c_start(); wr_byte(8'h48, ack); i2c_stop();
    chk(!ack, "R1 foreign address nack", ack, 0);
    chk(wr_cnt == wc0 && rd_cnt == rc0, "R1 no strobe", wr_cnt - wc0, 0);

    // R6 no auto-increment on writes
    wc0 = wr_cnt;
    i2c_start(); wr_byte(8'h4A, ack); wr_byte(8'h01, ack);
    wr_byte(8'h11, ack); wr_byte(8'h22, ack); i2c_stop();
    chk(wr_cnt - wc0 == 2, "R4 two strobes", wr_cnt - wc0, 2);
    chk(bank[1] == 8'h22 && bank[2] == 8'hA5, "R6 same register written", bank[1], 8'h22);

    // R6 R7 R9 R10 repeated reads, pointer kept over STOP
    rc0 = rd_cnt;
    i2c_start(); wr_byte(8'h4B, ack);
    rd_byte(1'b0, v); rd_byte(1'b1, v2);
    w(2);
    chk(!sda_oe, "R9 released after nack", sda_oe, 0);
    i2c_stop();
    chk(v == 8'h22 && v2 == 8'h22, "R6 R10 repeated read", v2, 8'h22);
    chk(rd_cnt - rc0 == 2, "R7 read strobes", rd_cnt - rc0, 2);

    // R10 abort mid-byte with repeated START
    wc0 = wr_cnt;
    i2c_start(); wr_byte(8'h4A, ack); wr_byte(8'h02, ack);
    begin logic s; for (int i = 0; i < 4; i++) bit_io(1'b1, s); end
    i2c_start(); i2c_stop();
    chk(wr_cnt == wc0 && bank[2] == 8'hA5, "R10 aborted byte ignored", wr_cnt - wc0, 0);
    i2c_start(); wr_byte(8'h4B, ack); rd_byte(1'b1, v); i2c_stop();
    chk(v == 8'hA5, "R10 pointer kept after abort", v, 8'hA5);

    // R8 invalid pointer: 0xFF, no read strobe
    i2c_start(); wr_byte(8'h4A, ack); wr_byte(8'h09, ack); i2c_stop();
    rc0 = rd_cnt;
    i2c_start(); wr_byte(8'h4B, ack); rd_byte(1'b1, v); i2c_stop();
    chk(v == 8'hFF, "R8 invalid pointer data", v, 8'hFF);
    chk(rd_cnt == rc0, "R8 no read strobe", rd_cnt - rc0, 0);

    // R12 reset clears pointer to 0
    i2c_start(); wr_byte(8'h4A, ack); wr_byte(8'h03, ack); i2c_stop();
    rst = 1'b1; w(3); rst = 1'b0; w(2);
    inport = 8'hC3;
    i2c_start(); wr_byte(8'h4B, ack); rd_byte(1'b1, v); i2c_stop();
    chk(v == 8'hC3, "R12 pointer reset to 0", v, 8'hC3);

    // R11 SDA never moved with SCL high
    chk(oe_hi_changes == 0, "R11 sda only while scl low", oe_hi_changes, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule